// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block produces the bypass multiplexer selects for a five-stage in-order pipeline. For each operand consumer it decides whether the value read from the register file can be used, or whether a newer result still travelling down the pipeline must take its place. Two producers are examined: the instruction in the memory stage, which holds the EX/MEM register, and the instruction in the write-back stage, which holds the MEM/WB register. Each producer's destination register is compared with the source registers of the instruction in the execute stage, which holds the ID/EX register.

Results can come from three places: the ALU result held in EX/MEM, the ALU result held in MEM/WB, and the load data held in MEM/WB. They can go to three consumers: ALU operand A (which also feeds the zero test), ALU operand B (which also carries store data through execute), and the data-memory write-data port of a store that is in the memory stage. In that last case, load data from MEM/WB is passed to the store behind the load.

The block is purely combinational. It has no state, no clock and no reset. The multiplexers and any stall logic sit outside it.

Top module: `fwd_unit`

## Requirements
- R1: Instruction kinds are encoded on 3 bits: 0 none, 1 register-register ALU, 2 register-immediate ALU, 3 load, 4 store, 5 branch. A producer's destination is its rd field for kind 1 and its rt field for kinds 2 and 3.
- R2: A producer can be forwarded only when its write-enable qualifier is 1 and its kind is 1, 2 or 3. Stores, branches, empty slots, undefined kinds and producers with write-enable at 0 never cause forwarding.
- R3: Register 0 is never forwarded. A source field of 0 always gives select 00, and the store-data select is 0 when the store's rt is 0.
- R4: ALU select A (`fwd_a_o`) is 01 when an eligible EX/MEM producer of kind 1 or 2 writes the ID/EX rs register.
- R5: When both EX/MEM and MEM/WB are eligible and write the same source register, EX/MEM wins and the select is 01.
- R6: The select is 10 when only MEM/WB matches. In that case `wb_is_load_o` is 1 if the MEM/WB instruction is a load and 0 otherwise, so it picks load data or the ALU result.
- R7: An EX/MEM load never gives select 01, because its ALU output is an address. The select then falls back to a matching MEM/WB producer, and to 00 if there is none.
- R8: ALU select B (`fwd_b_o`) follows the same rules as R3 to R7, applied to the ID/EX rt field.
- R9: `st_fwd_o` is 1 exactly when EX/MEM holds a store, MEM/WB holds a load with write-enable 1, both rt fields are equal, and that rt is not 0.
- R10: The code 11 never appears on either ALU select, and a select is 00 whenever no eligible producer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_rs_i | input | 5 | rs field of the instruction in execute |
| idex_rt_i | input | 5 | rt field of the instruction in execute |
| exmem_kind_i | input | 3 | Kind of the instruction in EX/MEM (R1 encoding) |
| exmem_wen_i | input | 1 | Register-write qualifier of EX/MEM |
| exmem_rd_i | input | 5 | rd field of EX/MEM |
| exmem_rt_i | input | 5 | rt field of EX/MEM |
| memwb_kind_i | input | 3 | Kind of the instruction in MEM/WB |
| memwb_wen_i | input | 1 | Register-write qualifier of MEM/WB |
| memwb_rd_i | input | 5 | rd field of MEM/WB |
| memwb_rt_i | input | 5 | rt field of MEM/WB |
| fwd_a_o | output | 2 | ALU operand A select: 00 register file, 01 EX/MEM ALU result, 10 MEM/WB result |
| fwd_b_o | output | 2 | ALU operand B / store data select, same codes as A |
| wb_is_load_o | output | 1 | For code 10: 1 selects MEM/WB load data, 0 selects the MEM/WB ALU result |
| st_fwd_o | output | 1 | Store write data: 1 selects MEM/WB load data, 0 keeps the carried value |

## Verification
The hardest case to reach is the one where both producers are eligible and both aim at the same nonzero register that a consumer reads. The case is harder still when the EX/MEM producer is a load that must be passed over, or when a load in MEM/WB and a store in EX/MEM share an rt. Uniform random fields over 32 registers almost never line up like this. The random stimulus therefore draws every register field from registers 0 to 3, with register 0 included on purpose, and draws every kind from all eight codes. Directed cases then pin down each priority and each exclusion exactly.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_NONE   = 3'd0,
    K_ALU_RR = 3'd1,
    K_ALU_RI = 3'd2,
    K_LOAD   = 3'd3,
    K_STORE  = 3'd4,
    K_BRANCH = 3'd5
  } kind_e;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_EXM = 2'b01,
    SEL_MWB = 2'b10
  } alu_sel_e;

  function automatic logic kind_writes(input logic [KIND_W-1:0] k);
    return (k == K_ALU_RR) || (k == K_ALU_RI) || (k == K_LOAD);
  endfunction
endpackage

// File: rtl/fwd_dest_decode.sv
// Resolves which register, if any, a stage will write.
module fwd_dest_decode
  import fwd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [KIND_W-1:0] kind_i,
  input  logic              wen_i,
  input  logic [REG_AW-1:0] rd_i,
  input  logic [REG_AW-1:0] rt_i,
  output logic              live_o,
  output logic              is_load_o,
  output logic [REG_AW-1:0] dest_o
);
  logic [REG_AW-1:0] dest;

  always_comb begin
    dest = (kind_i == K_ALU_RR) ? rd_i : rt_i;
  end

  assign dest_o    = dest;
  assign is_load_o = (kind_i == K_LOAD);
  // register 0 is hardwired, never a live destination
  assign live_o    = wen_i && kind_writes(kind_i) && (dest != '0);
endmodule

// File: rtl/fwd_alu_sel.sv
// One ALU-side bypass select; newest eligible producer wins.
module fwd_alu_sel
  import fwd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic              ex_live_i,
  input  logic              ex_is_load_i,
  input  logic [REG_AW-1:0] ex_dest_i,
  input  logic              wb_live_i,
  input  logic [REG_AW-1:0] wb_dest_i,
  output logic [1:0]        sel_o
);
  logic ex_hit, wb_hit;

  // a load in EX/MEM has only an address in its ALU output
  assign ex_hit = ex_live_i && !ex_is_load_i && (ex_dest_i == src_i);
  assign wb_hit = wb_live_i && (wb_dest_i == src_i);

  always_comb begin
    if (ex_hit)      sel_o = SEL_EXM;
    else if (wb_hit) sel_o = SEL_MWB;
    else             sel_o = SEL_RF;
  end
endmodule

// File: rtl/fwd_store_sel.sv
// Load-to-store write data bypass in the memory stage.
module fwd_store_sel
  import fwd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [KIND_W-1:0] st_kind_i,
  input  logic [REG_AW-1:0] st_rt_i,
  input  logic              ld_live_i,
  input  logic              ld_is_load_i,
  input  logic [REG_AW-1:0] ld_dest_i,
  output logic              sel_o
);
  assign sel_o = (st_kind_i == K_STORE) && ld_live_i && ld_is_load_i
               && (ld_dest_i == st_rt_i);
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_AW = 5,
  localparam int unsigned N_SINK = 2
) (
  input  logic [REG_AW-1:0] idex_rs_i,
  input  logic [REG_AW-1:0] idex_rt_i,
  input  logic [2:0]        exmem_kind_i,
  input  logic              exmem_wen_i,
  input  logic [REG_AW-1:0] exmem_rd_i,
  input  logic [REG_AW-1:0] exmem_rt_i,
  input  logic [2:0]        memwb_kind_i,
  input  logic              memwb_wen_i,
  input  logic [REG_AW-1:0] memwb_rd_i,
  input  logic [REG_AW-1:0] memwb_rt_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              wb_is_load_o,
  output logic              st_fwd_o
);
  logic              ex_live, ex_load, wb_live, wb_load;
  logic [REG_AW-1:0] ex_dest, wb_dest;
  logic [REG_AW-1:0] srcs [N_SINK];
  logic [1:0]        sels [N_SINK];

  fwd_dest_decode #(.REG_AW(REG_AW)) u_ex_dec (
    .kind_i(exmem_kind_i), .wen_i(exmem_wen_i), .rd_i(exmem_rd_i), .rt_i(exmem_rt_i),
    .live_o(ex_live), .is_load_o(ex_load), .dest_o(ex_dest)
  );

  fwd_dest_decode #(.REG_AW(REG_AW)) u_wb_dec (
    .kind_i(memwb_kind_i), .wen_i(memwb_wen_i), .rd_i(memwb_rd_i), .rt_i(memwb_rt_i),
    .live_o(wb_live), .is_load_o(wb_load), .dest_o(wb_dest)
  );

  assign srcs[0] = idex_rs_i;
  assign srcs[1] = idex_rt_i;

  for (genvar g = 0; g < N_SINK; g++) begin : g_sink
    fwd_alu_sel #(.REG_AW(REG_AW)) u_sel (
      .src_i(srcs[g]),
      .ex_live_i(ex_live), .ex_is_load_i(ex_load), .ex_dest_i(ex_dest),
      .wb_live_i(wb_live), .wb_dest_i(wb_dest),
      .sel_o(sels[g])
    );
  end

  fwd_store_sel #(.REG_AW(REG_AW)) u_st (
    .st_kind_i(exmem_kind_i), .st_rt_i(exmem_rt_i),
    .ld_live_i(wb_live), .ld_is_load_i(wb_load), .ld_dest_i(wb_dest),
    .sel_o(st_fwd_o)
  );

  assign fwd_a_o      = sels[0];
  assign fwd_b_o      = sels[1];
  assign wb_is_load_o = wb_load;
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned REG_AW = 5
) (
  input logic [REG_AW-1:0] idex_rs_i,
  input logic [REG_AW-1:0] idex_rt_i,
  input logic [2:0]        exmem_kind_i,
  input logic              exmem_wen_i,
  input logic [REG_AW-1:0] exmem_rd_i,
  input logic [REG_AW-1:0] exmem_rt_i,
  input logic [2:0]        memwb_kind_i,
  input logic              memwb_wen_i,
  input logic [REG_AW-1:0] memwb_rd_i,
  input logic [REG_AW-1:0] memwb_rt_i,
  input logic [1:0]        fwd_a_o,
  input logic [1:0]        fwd_b_o,
  input logic              wb_is_load_o,
  input logic              st_fwd_o
);
  logic unused_ok;
  assign unused_ok = ^{exmem_rd_i, memwb_rd_i, wb_is_load_o};

  always_comb begin
    a_r10_no_code3: assert (fwd_a_o != 2'b11 && fwd_b_o != 2'b11)
      else $error("select code 11 seen");
    a_r3_zero_src: assert ((idex_rs_i != '0 || fwd_a_o == 2'b00) &&
                           (idex_rt_i != '0 || fwd_b_o == 2'b00))
      else $error("register 0 forwarded");
    a_r2_no_writers: assert ((exmem_wen_i || memwb_wen_i) ||
                             (fwd_a_o == 2'b00 && fwd_b_o == 2'b00 && !st_fwd_o))
      else $error("forward without any write enable");
    a_r7_ex_load: assert (exmem_kind_i != 3'd3 ||
                          (fwd_a_o != 2'b01 && fwd_b_o != 2'b01))
      else $error("EX/MEM load forwarded its address");
    a_r9_store_pair: assert (!st_fwd_o || (exmem_kind_i == 3'd4 && memwb_kind_i == 3'd3 &&
                             memwb_wen_i && exmem_rt_i == memwb_rt_i && exmem_rt_i != '0))
      else $error("store data bypass without load/store pair");
  end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/sim_fwd_unit.sv
`timescale 1ns/1ps
module sim_fwd_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [4:0] rs, rt, ex_rd, ex_rt, wb_rd, wb_rt;
  logic [2:0] ex_kind, wb_kind;
  logic       ex_wen, wb_wen;
  logic [1:0] fa, fb;
  logic       wbl, stf;
  int total = 0, bad = 0;

  fwd_unit u0 (
    .idex_rs_i(rs), .idex_rt_i(rt),
    .exmem_kind_i(ex_kind), .exmem_wen_i(ex_wen), .exmem_rd_i(ex_rd), .exmem_rt_i(ex_rt),
    .memwb_kind_i(wb_kind), .memwb_wen_i(wb_wen), .memwb_rd_i(wb_rd), .memwb_rt_i(wb_rt),
    .fwd_a_o(fa), .fwd_b_o(fb), .wb_is_load_o(wbl), .st_fwd_o(stf)
  );

  // reference from R1/R2: destination and eligibility
  function automatic logic [5:0] ref_dest(input logic [2:0] k, input logic w,
                                          input logic [4:0] d, input logic [4:0] t);
    logic [4:0] r;
    r = (k == 3'd1) ? d : t;
    if (w && (k == 3'd1 || k == 3'd2 || k == 3'd3) && r != 5'd0) return {1'b1, r};
    return 6'd0;
  endfunction

  function automatic logic [1:0] ref_sel(input logic [4:0] s);
    logic [5:0] e, m;
    e = ref_dest(ex_kind, ex_wen, ex_rd, ex_rt);
    m = ref_dest(wb_kind, wb_wen, wb_rd, wb_rt);
    if (e[5] && ex_kind != 3'd3 && e[4:0] == s) return 2'b01;  // R4, R5, R7
    if (m[5] && m[4:0] == s) return 2'b10;                     // R6
    return 2'b00;
  endfunction

  function automatic logic ref_st();
    return ex_kind == 3'd4 && wb_kind == 3'd3 && wb_wen && ex_rt == wb_rt && ex_rt != 5'd0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] s1, input logic [4:0] s2,
                       input logic [2:0] ek, input logic ew, input logic [4:0] ed, input logic [4:0] et,
                       input logic [2:0] wk, input logic ww, input logic [4:0] wd, input logic [4:0] wt);
    @(negedge clk);
    rs = s1; rt = s2; ex_kind = ek; ex_wen = ew; ex_rd = ed; ex_rt = et;
    wb_kind = wk; wb_wen = ww; wb_rd = wd; wb_rt = wt;
    #1;
  endtask

  task automatic check_all(input string req);
    chk({req, " A"}, fa, ref_sel(rs));
    chk({req, " B"}, fb, ref_sel(rt));
    chk({req, " ld"}, wbl, (wb_kind == 3'd3));
    chk({req, " st"}, stf, ref_st());
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // idle state: nothing in flight
    drive(5'd3, 5'd4, 3'd0, 1'b0, 5'd3, 5'd4, 3'd0, 1'b0, 5'd3, 5'd4);
    chk("R10 idle A", fa, 0); chk("R10 idle B", fb, 0); chk("R9 idle st", stf, 0);
    // R1 rd destination for kind 1, rt ignored
    drive(5'd7, 5'd9, 3'd1, 1'b1, 5'd7, 5'd9, 3'd0, 1'b0, 5'd0, 5'd0);
    chk("R1/R4 rr rd", fa, 1); chk("R1 rr not rt", fb, 0);
    // R1 rt destination for kind 2
    drive(5'd7, 5'd9, 3'd2, 1'b1, 5'd7, 5'd9, 3'd0, 1'b0, 5'd0, 5'd0);
    chk("R1 ri not rd", fa, 0); chk("R1/R8 ri rt", fb, 1);
    // R2 store/branch/wen off
    drive(5'd6, 5'd6, 3'd4, 1'b1, 5'd6, 5'd6, 3'd5, 1'b1, 5'd6, 5'd6);
    chk("R2 store/branch A", fa, 0); chk("R2 store/branch B", fb, 0);
    drive(5'd6, 5'd6, 3'd1, 1'b0, 5'd6, 5'd6, 3'd2, 1'b0, 5'd6, 5'd6);
    chk("R2 wen off", fa, 0);
    // R3 register 0
    drive(5'd0, 5'd0, 3'd1, 1'b1, 5'd0, 5'd0, 3'd3, 1'b1, 5'd0, 5'd0);
    chk("R3 zero A", fa, 0); chk("R3 zero B", fb, 0);
    drive(5'd1, 5'd1, 3'd4, 1'b0, 5'd0, 5'd0, 3'd3, 1'b1, 5'd0, 5'd0);
    chk("R3 zero st", stf, 0);
    // R5 priority
    drive(5'd5, 5'd5, 3'd2, 1'b1, 5'd0, 5'd5, 3'd1, 1'b1, 5'd5, 5'd0);
    chk("R5 prio A", fa, 1); chk("R5/R8 prio B", fb, 1);
    // R6 mem/wb only, load
    drive(5'd8, 5'd2, 3'd0, 1'b0, 5'd0, 5'd0, 3'd3, 1'b1, 5'd0, 5'd8);
    chk("R6 wb A", fa, 2); chk("R6 wb B", fb, 0); chk("R6 is load", wbl, 1);
    drive(5'd2, 5'd8, 3'd0, 1'b0, 5'd0, 5'd0, 3'd1, 1'b1, 5'd8, 5'd0);
    chk("R6 wb alu", fb, 2); chk("R6 not load", wbl, 0);
    // R7 EX/MEM load falls through
    drive(5'd4, 5'd4, 3'd3, 1'b1, 5'd0, 5'd4, 3'd2, 1'b1, 5'd0, 5'd4);
    chk("R7 ex load A", fa, 2); chk("R7 ex load B", fb, 2);
    drive(5'd4, 5'd9, 3'd3, 1'b1, 5'd0, 5'd4, 3'd0, 1'b0, 5'd0, 5'd0);
    chk("R7 ex load none", fa, 0);
    // R9 load then store
    drive(5'd0, 5'd0, 3'd4, 1'b0, 5'd0, 5'd12, 3'd3, 1'b1, 5'd0, 5'd12);
    chk("R9 ld-st", stf, 1);
    drive(5'd0, 5'd0, 3'd4, 1'b0, 5'd0, 5'd12, 3'd2, 1'b1, 5'd0, 5'd12);
    chk("R9 alu-st", stf, 0);
    drive(5'd0, 5'd0, 3'd4, 1'b0, 5'd0, 5'd12, 3'd3, 1'b1, 5'd0, 5'd13);
    chk("R9 mismatch", stf, 0);
    // random: R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 3000; i++) begin
      drive(5'($urandom % 4), 5'($urandom % 4),
            3'($urandom % 8), 1'($urandom), 5'($urandom % 4), 5'($urandom % 4),
            3'($urandom % 8), 1'($urandom), 5'($urandom % 4), 5'($urandom % 4));
      check_all("R4-8 rnd");
      chk("R10 rnd", int'(fa == 2'b11 || fb == 2'b11), 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule